// File: doc/BRIEF.md
# Four-bit GPIO Port with Change Interrupt

This block is the register and pin core of a small general-purpose I/O port. A bus front end, which decodes the serial protocol elsewhere, hands it single-cycle write and read strobes with a two-bit register select. Three registers control the pins: a per-pin direction register, an output drive register and a read-back inversion register. A fourth, read-only view returns the synchronized pin levels. Each pin is either an input, with its driver released, or an output that drives its drive-register bit.

The block also watches its pins for changes. Every read of the pin view stores the synchronized pin levels as a snapshot. Whenever an input-configured pin differs from its snapshot bit, the block raises an open-drain interrupt request, modelled here as a pull-low enable. The request clears when the pin goes back to its stored level, or when the pin view is read again. Inversion changes only the data returned by a read; it never changes what the interrupt compares.

Top module: `pinbank_core`

## Requirements
- R1: While `rst` is high at a rising edge, and right after it: `pin_oe` = 0000, `pin_out` = 0000, `rd_data` = 0x00 and `irq_pull` = 0. The direction register resets to 1111, the drive register to 1111 and the inversion register to 0000.
- R2: `reg_sel` codes are 0 pin view, 1 drive, 2 inversion and 3 direction, with data in `wr_data[3:0]`. A direction bit of 1 makes the pin an input (`pin_oe` bit 0, `pin_out` bit 0). A direction bit of 0 makes it an output (`pin_oe` bit 1, `pin_out` bit equal to its drive bit). A write takes effect at the edge that samples `wr_en`.
- R3: A read of the drive register returns the stored drive bits, whatever level the pin carries.
- R4: A read of the pin view returns the synchronized level of every pin, inputs and outputs alike, XORed with the inversion bits. Bits 7..4 read as 1. A write with select 0 changes no register, no read-back value and no interrupt state.
- R5: Bits 7..4 read as 1 for the drive and direction registers and as 0 for the inversion register. Writes to bits 7..4 are ignored.
- R6: `rd_data` loads the selected value at the edge that samples `rd_en` and holds it until the next read. A read in the same cycle as a write returns the old register value.
- R7: Each pin passes through a two-stage synchronizer. A pin change made before edge k becomes visible to reads and to the interrupt after edge k+1.
- R8: `irq_pull` is 1 exactly when the block has settled and some input-configured pin's synchronized level differs from its snapshot bit. Output pins and the inversion bits have no effect on it.
- R9: A read with select 0 loads the snapshot with the synchronized pins at that edge, which clears `irq_pull` if the pins are steady. A pin that returns to its snapshot level also clears it.
- R10: Turning an output pin into an input raises `irq_pull` at that write's edge if the pin's synchronized level differs from its snapshot bit.
- R11: For the first three edges after reset release, the snapshot follows the synchronized pins and `irq_pull` is held at 0. Pins steady through reset therefore raise no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe, one cycle |
| rd_en | input | 1 | Read strobe, one cycle |
| reg_sel | input | 2 | Register select for both strobes |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| pin_in | input | 4 | Asynchronous pin levels |
| pin_out | output | 4 | Pin drive value, 0 for input pins |
| pin_oe | output | 4 | Pin driver enable, 1 for output pins |
| irq_pull | output | 1 | Pull-low enable of the open-drain interrupt line |

## Verification
A corrupted direction or drive bit shows on `pin_oe` or `pin_out` in the same cycle, with no read needed. A wrong snapshot bit appears on `irq_pull` as soon as the matching pin is an input. A snapshot left stale after a read keeps the request raised in the next cycle. Synchronizer depth errors move interrupt and read-back timing by whole cycles, so the bench compares every output against its model on every clock and catches them at the first pin change.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;

    localparam int PORT_W = 4;
    localparam int BUS_W  = 8;
    localparam int PAD_W  = BUS_W - PORT_W;

    typedef enum logic [1:0] {
        SEL_PINS   = 2'd0,
        SEL_DRIVE  = 2'd1,
        SEL_INVERT = 2'd2,
        SEL_DIR    = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [PORT_W-1:0] drive;
        logic [PORT_W-1:0] invert;
        logic [PORT_W-1:0] dir;
    } ctrl_regs_t;

    localparam ctrl_regs_t CTRL_RESET = '{drive: '1, invert: '0, dir: '1};

    function automatic logic [BUS_W-1:0] widen(input logic [PORT_W-1:0] v, input logic fill);
        return {{PAD_W{fill}}, v};
    endfunction

endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
    parameter int N      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    logic [N-1:0] stage [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage[0] <= '0;
                else     stage[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage[g] <= '0;
                else     stage[g] <= stage[g-1];
            end
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/pinbank_regs.sv
module pinbank_regs
    import pinbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        sel,
    input  logic [BUS_W-1:0]  wr_data,
    input  logic [PORT_W-1:0] pins_sync,
    output ctrl_regs_t        ctrl,
    output logic [BUS_W-1:0]  rd_data
);
    reg_sel_e sel_e;
    assign sel_e = reg_sel_e'(sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= CTRL_RESET;
        end else if (wr_en) begin
            unique case (sel_e)
                SEL_DRIVE:  ctrl.drive  <= wr_data[PORT_W-1:0];
                SEL_INVERT: ctrl.invert <= wr_data[PORT_W-1:0];
                SEL_DIR:    ctrl.dir    <= wr_data[PORT_W-1:0];
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_en) begin
            unique case (sel_e)
                SEL_PINS:   rd_data <= widen(pins_sync ^ ctrl.invert, 1'b1);
                SEL_DRIVE:  rd_data <= widen(ctrl.drive, 1'b1);
                SEL_INVERT: rd_data <= widen(ctrl.invert, 1'b0);
                default:    rd_data <= widen(ctrl.dir, 1'b1);
            endcase
        end
    end

    // R6: read data holds between reads
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));

    // R5: pad bits of every register except inversion read as ones
    a_r5_pad_ones: assert property (@(posedge clk) disable iff (rst)
        (rd_en && sel_e != SEL_INVERT) |=> rd_data[BUS_W-1:PORT_W] == '1);

    // R5: inversion pad bits read as zeros
    a_r5_pad_zeros: assert property (@(posedge clk) disable iff (rst)
        (rd_en && sel_e == SEL_INVERT) |=> rd_data[BUS_W-1:PORT_W] == '0);
endmodule

// File: rtl/pinbank_chg.sv
module pinbank_chg
    import pinbank_pkg::*;
#(
    parameter int SETTLE = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_pins,
    input  logic [PORT_W-1:0] pins_sync,
    input  logic [PORT_W-1:0] dir,
    output logic              irq
);
    localparam int CW = $clog2(SETTLE + 1);

    logic [CW-1:0]     settle_cnt;
    logic              settled;
    logic [PORT_W-1:0] snap;

    assign settled = (settle_cnt == CW'(SETTLE));

    always_ff @(posedge clk) begin
        if (rst) begin
            settle_cnt <= '0;
            snap       <= '0;
        end else begin
            if (!settled) settle_cnt <= settle_cnt + 1'b1;
            if (!settled || rd_pins) snap <= pins_sync;
        end
    end

    assign irq = settled && |((pins_sync ^ snap) & dir);

    // R9: a read of the pin view clears the request if the pins hold still
    a_r9_read_clears: assert property (@(posedge clk) disable iff (rst)
        rd_pins |=> (!irq || pins_sync != $past(pins_sync)));

    // R8: with every pin an output, no request is possible
    a_r8_outputs_quiet: assert property (@(posedge clk) disable iff (rst)
        (dir == '0) |-> !irq);

    // R11: no request in the first cycle after reset
    a_r11_masked: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !irq);
endmodule

// File: rtl/pinbank_core.sv
module pinbank_core
    import pinbank_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        reg_sel,
    input  logic [BUS_W-1:0]  wr_data,
    output logic [BUS_W-1:0]  rd_data,
    input  logic [PORT_W-1:0] pin_in,
    output logic [PORT_W-1:0] pin_out,
    output logic [PORT_W-1:0] pin_oe,
    output logic              irq_pull
);
    localparam int SETTLE = SYNC_STAGES + 1;

    logic [PORT_W-1:0] pins_sync;
    ctrl_regs_t        ctrl;
    logic              rd_pins;

    pinbank_sync #(.N(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (pins_sync)
    );

    pinbank_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .sel       (reg_sel),
        .wr_data   (wr_data),
        .pins_sync (pins_sync),
        .ctrl      (ctrl),
        .rd_data   (rd_data)
    );

    assign rd_pins = rd_en && (reg_sel_e'(reg_sel) == SEL_PINS);

    pinbank_chg #(.SETTLE(SETTLE)) u_chg (
        .clk       (clk),
        .rst       (rst),
        .rd_pins   (rd_pins),
        .pins_sync (pins_sync),
        .dir       (ctrl.dir),
        .irq       (irq_pull)
    );

    assign pin_oe  = ~ctrl.dir;
    assign pin_out = ctrl.drive & ~ctrl.dir;

    // R2: a direction write shows on the enables one cycle later
    a_r2_dir_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && reg_sel_e'(reg_sel) == SEL_DIR) |=> pin_oe == ~$past(wr_data[PORT_W-1:0]));

    // R1: leaving reset, all pins are inputs and nothing is driven
    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pin_oe == '0 && pin_out == '0 && rd_data == '0));
endmodule

// File: tb/pinbank_core_tb_top.sv
module pinbank_core_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic [3:0] pin_in = 4'b1010;
    logic [3:0] pin_out;
    logic [3:0] pin_oe;
    logic       irq_pull;

    int    n_vec  = 0;
    int    n_bad  = 0;
    bit    started = 1'b0;
    bit    done    = 1'b0;
    string phase   = "R1";

    always #4 clk = ~clk;

    pinbank_core dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .reg_sel(reg_sel),
        .wr_data(wr_data), .rd_data(rd_data), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq_pull(irq_pull)
    );

    // behavioural reference: registers, a pipeline of pin samples, a snapshot, an age counter
    logic [3:0] m_drive = 4'hF, m_inv = 4'h0, m_dir = 4'hF, m_snap = 4'h0;
    logic [7:0] m_rd = 8'h00;
    logic [3:0] m_hist [$];
    int         m_age = 0;

    function automatic logic [3:0] m_seen();
        return (m_hist.size() >= 2) ? m_hist[1] : 4'h0;
    endfunction

    function automatic logic m_irq();
        return (m_age >= 3) && (((m_seen() ^ m_snap) & m_dir) != 4'h0);
    endfunction

    always @(posedge clk) begin
        logic [3:0] seen;
        started <= 1'b1;
        seen = m_seen();
        if (rst) begin
            m_drive = 4'hF; m_inv = 4'h0; m_dir = 4'hF; m_snap = 4'h0;
            m_rd = 8'h00; m_age = 0;
            m_hist = {};
        end else begin
            if (rd_en) begin
                case (reg_sel)
                    2'd0: m_rd = {4'hF, seen ^ m_inv};
                    2'd1: m_rd = {4'hF, m_drive};
                    2'd2: m_rd = {4'h0, m_inv};
                    default: m_rd = {4'hF, m_dir};
                endcase
            end
            if (m_age < 3 || (rd_en && reg_sel == 2'd0)) m_snap = seen;
            if (m_age < 3) m_age++;
            if (wr_en) begin
                if (reg_sel == 2'd1) m_drive = wr_data[3:0];
                if (reg_sel == 2'd2) m_inv   = wr_data[3:0];
                if (reg_sel == 2'd3) m_dir   = wr_data[3:0];
            end
            m_hist.push_front(pin_in);
            if (m_hist.size() > 2) void'(m_hist.pop_back());
        end
    end

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started && !done) begin
            chk(phase, "rd_data", rd_data, m_rd);
            chk(phase, "pin_out", {4'h0, pin_out}, {4'h0, m_drive & ~m_dir});
            chk(phase, "pin_oe", {4'h0, pin_oe}, {4'h0, ~m_dir});
            chk(phase, "irq_pull", {7'h0, irq_pull}, {7'h0, m_irq()});
        end
    end

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        wr_en = 1'b1; reg_sel = s; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s);
        rd_en = 1'b1; reg_sel = s;
        tick();
        rd_en = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        tick(2);
        phase = "R1";
        chk("R1", "oe in reset", {4'h0, pin_oe}, 8'h00);
        chk("R1", "out in reset", {4'h0, pin_out}, 8'h00);
        chk("R1", "rd in reset", rd_data, 8'h00);
        chk("R1", "irq in reset", {7'h0, irq_pull}, 8'h00);
        rst = 1'b0;
        phase = "R11";
        tick(5);
        chk("R11", "irq after settle", {7'h0, irq_pull}, 8'h00);

        phase = "R5";
        rd(2'd1); chk("R5", "drive default", rd_data, 8'hFF);
        rd(2'd2); chk("R5", "invert default", rd_data, 8'h00);
        rd(2'd3); chk("R5", "dir default", rd_data, 8'hFF);
        phase = "R4";
        rd(2'd0); chk("R4", "pin view", rd_data, 8'hFA);

        phase = "R2";
        wr(2'd3, 8'h0C);
        wr(2'd1, 8'hF5);
        chk("R2", "oe", {4'h0, pin_oe}, 8'h03);
        chk("R2", "out", {4'h0, pin_out}, 8'h01);
        phase = "R3";
        rd(2'd1); chk("R3", "drive readback", rd_data, 8'hF5);

        phase = "R4";
        wr(2'd2, 8'h03);
        rd(2'd0); chk("R4", "inverted view", rd_data, 8'hF9);

        phase = "R8";
        pin_in = 4'b1000;
        tick(3); chk("R8", "output pin ignored", {7'h0, irq_pull}, 8'h00);
        rd(2'd0); chk("R4", "view of output pin", rd_data, 8'hFB);

        phase = "R7";
        pin_in = 4'b1100;
        tick(1); chk("R7", "not yet through sync", {7'h0, irq_pull}, 8'h00);
        tick(1); chk("R8", "input change raises", {7'h0, irq_pull}, 8'h01);
        phase = "R9";
        pin_in = 4'b1000;
        tick(2); chk("R9", "return clears", {7'h0, irq_pull}, 8'h00);

        pin_in = 4'b0000;
        tick(2); chk("R8", "pin3 raises", {7'h0, irq_pull}, 8'h01);
        rd(2'd0);
        chk("R9", "read data", rd_data, 8'hF3);
        chk("R9", "read clears", {7'h0, irq_pull}, 8'h00);

        phase = "R4";
        wr(2'd0, 8'h55);
        rd(2'd0); chk("R4", "pin view write ignored", rd_data, 8'hF3);
        chk("R4", "irq untouched by write", {7'h0, irq_pull}, 8'h00);
        rd(2'd3); chk("R4", "dir untouched", rd_data, 8'hFC);

        phase = "R10";
        pin_in = 4'b0001;
        tick(3); chk("R10", "output level ignored", {7'h0, irq_pull}, 8'h00);
        wr(2'd3, 8'h0D);
        chk("R10", "flip to input raises", {7'h0, irq_pull}, 8'h01);
        phase = "R8";
        wr(2'd2, 8'h00);
        chk("R8", "inversion ignored", {7'h0, irq_pull}, 8'h01);

        phase = "R5";
        wr(2'd2, 8'hF0);
        rd(2'd2); chk("R5", "pad write ignored", rd_data, 8'h00);

        phase = "R6";
        wr_en = 1'b1; rd_en = 1'b1; reg_sel = 2'd1; wr_data = 8'h0A;
        tick();
        wr_en = 1'b0; rd_en = 1'b0;
        chk("R6", "read old value", rd_data, 8'hF5);
        tick(3);
        chk("R6", "held", rd_data, 8'hF5);

        phase = "R1";
        rst = 1'b1;
        tick(2);
        chk("R1", "oe after mid reset", {4'h0, pin_oe}, 8'h00);
        chk("R1", "rd after mid reset", rd_data, 8'h00);
        rst = 1'b0;
        phase = "R11";
        tick(5);
        chk("R11", "steady pins no irq", {7'h0, irq_pull}, 8'h00);
        rd(2'd0); chk("R11", "view after reset", rd_data, 8'hF1);

        phase = "R8";
        lfsr = 16'hACE1;
        for (int i = 0; i < 600; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[2:0] == 3'd0) pin_in = lfsr[7:4];
            wr_en   = (lfsr[9:8] == 2'd1);
            rd_en   = lfsr[10];
            reg_sel = lfsr[12:11];
            wr_data = lfsr[15:8];
            tick();
        end
        wr_en = 1'b0; rd_en = 1'b0;
        tick(2);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule